// File: doc/BRIEF.md
# Monitor Channel Handshake Receiver

This block sits on the receive side of the per-frame monitor byte of a TDM serial bus. Once per frame, marked by a one-cycle frame strobe, it samples the sender's active-low transmit flag and the monitor byte. It answers on an active-low acknowledge flag. Every byte it accepts is placed in a one-entry output register, marked by a valid flag, and it stays there until a downstream ready input takes it.

Byte boundaries are found only from the frame pattern of the transmit flag. A single inactive frame separates two bytes. Two inactive frames right after an acknowledged byte close the message. Two inactive frames while the next byte is still unacknowledged abort it. When the output register is still full, the block stalls the sender by keeping the acknowledge flag active. An abort sets a sticky status bit that is cleared by writing 1 to it. An interrupt output combines the status bits with a mask register.

Top module: `mon_rx_handshake`

## Requirements
- R1: After reset, mr_n is 1, byte_valid is 0, and status, mask and irq are all 0.
- R2: While idle with the output register empty, a strobed frame with mx_n = 0 loads mon_byte into byte_data, sets byte_valid and drives mr_n to 0, all at that same clock edge.
- R3: mr_n changes only on the clock edge that samples frame_stb = 1. Changes of mx_n or mon_byte between strobes have no effect.
- R4: A byte repeated while mx_n stays 0 is not output again. The next byte is taken only after mx_n has been 1 for one strobed frame and then 0 again. In that reactivation frame mr_n goes to 1, and at the next strobe the byte is loaded and mr_n returns to 0.
- R5: If byte_valid is still 1 when mx_n reactivates, mr_n stays 0 for as long as the output register is full. The release to 1 happens at the first strobe that finds the register empty with mx_n = 0.
- R6: byte_valid falls on the clock edge that samples byte_ready = 1. Otherwise byte_valid and byte_data hold.
- R7: Two consecutive strobed frames with mx_n = 1 following an acknowledged byte end the message: mr_n returns to 1 and status is not changed.
- R8: While a reactivated byte is unacknowledged (mr_n released, or held off), ABORT_FRAMES consecutive strobed frames with mx_n = 1 abort the transfer. This sets status bit 3 (ABORT_BIT) and returns mr_n to 1.
- R9: irq is 1 exactly when some status bit and the same mask bit are both 1. The mask register takes mask_wdata on a clock with mask_we = 1.
- R10: A clock with stat_clr_we = 1 clears each status bit whose stat_clr_data bit is 1. Other bits are unchanged, and a new abort in the same cycle wins.
- R11: While idle with byte_valid = 1, frames with mx_n = 0 are not accepted and mr_n stays 1. The byte is accepted at the first such strobe that finds the register empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per bus frame |
| mx_n | input | 1 | Sender transmit flag, active low |
| mon_byte | input | DATA_W | Monitor byte of the current frame |
| mr_n | output | 1 | Receiver acknowledge flag, active low |
| byte_valid | output | 1 | Output register holds a byte |
| byte_data | output | DATA_W | Accepted byte |
| byte_ready | input | 1 | Downstream takes the byte |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | REG_W | Mask write data |
| stat_clr_we | input | 1 | Status write-1-to-clear enable |
| stat_clr_data | input | REG_W | Status bits to clear |
| status | output | REG_W | Status register, bit ABORT_BIT = abort |
| mask | output | REG_W | Interrupt mask register |
| irq | output | 1 | Interrupt request |

## Verification
A wrong handshake state shows on mr_n at the very next strobe. An early or late release, or a missed abort, is visible within one frame, and a byte counted twice shows as an extra byte_valid pulse on the same clock. A corrupted abort counter moves the status bit and irq one strobe earlier or later. A lost clear or a lost mask write shows on irq on the clock after the write.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACK,
      ST_GAP,
      ST_HOLD,
      ST_REL
   } mon_state_e;
endpackage

// File: rtl/mon_rx_fsm.sv
module mon_rx_fsm
   import mon_rx_pkg::*;
#(
   parameter int ABORT_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic mx_n,
   input  logic buf_busy,
   output logic mr_n,
   output logic load,
   output logic abort_evt
);
   localparam int CNT_W = $clog2(ABORT_FRAMES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ABORT_FRAMES - 1);

   initial begin
      if (ABORT_FRAMES < 2) $fatal(1, "ABORT_FRAMES must be at least 2");
   end

   mon_state_e st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d = st_q;
      cnt_d = cnt_q;
      load = 1'b0;
      abort_evt = 1'b0;
      if (frame_stb) begin
         unique case (st_q)
            ST_IDLE: if (!mx_n && !buf_busy) begin
               load = 1'b1;
               st_d = ST_ACK;
            end
            ST_ACK: if (mx_n) st_d = ST_GAP;
            ST_GAP: begin
               if (mx_n) st_d = ST_IDLE;
               else begin
                  cnt_d = '0;
                  st_d = buf_busy ? ST_HOLD : ST_REL;
               end
            end
            ST_HOLD, ST_REL: begin
               if (mx_n) begin
                  if (cnt_q == CNT_LAST) begin
                     abort_evt = 1'b1;
                     st_d = ST_IDLE;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end else begin
                  cnt_d = '0;
                  if (st_q == ST_REL) begin
                     load = 1'b1;
                     st_d = ST_ACK;
                  end else if (!buf_busy) begin
                     st_d = ST_REL;
                  end
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign mr_n = (st_q == ST_IDLE) || (st_q == ST_REL);

   assert_mr_only_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(mr_n));
   assert_load_acks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !mr_n);
   assert_abort_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> mr_n);
endmodule

// File: rtl/mon_rx_outbuf.sv
module mon_rx_outbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);
   initial begin
      if (DATA_W < 1) $fatal(1, "DATA_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout <= din;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   assert_held_until_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/mon_rx_regs.sv
module mon_rx_regs #(
   parameter int REG_W     = 8,
   parameter int ABORT_BIT = 3,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_evt,
   input  logic             mask_we,
   input  logic [REG_W-1:0] mask_wdata,
   input  logic             clr_we,
   input  logic [REG_W-1:0] clr_data,
   output logic [REG_W-1:0] status,
   output logic [REG_W-1:0] mask,
   output logic             irq
);
   initial begin
      if (ABORT_BIT >= REG_W) $fatal(1, "ABORT_BIT outside register");
   end

   logic [REG_W-1:0] set_vec;
   assign set_vec = abort_evt ? (REG_W'(1) << ABORT_BIT) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask <= '0;
      end else begin
         status <= (status & ~(clr_we ? clr_data : '0)) | set_vec;
         if (mask_we) mask <= mask_wdata;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else irq <= |(status & mask);
         end
      end else begin : g_irq_comb
         assign irq = |(status & mask);
      end
   endgenerate

   assert_abort_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> status[ABORT_BIT]);
   assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_data[ABORT_BIT] && !abort_evt) |=> !status[ABORT_BIT]);
endmodule

// File: rtl/mon_rx_handshake.sv
module mon_rx_handshake #(
   parameter int DATA_W       = 8,
   parameter int REG_W        = 8,
   parameter int ABORT_BIT    = 3,
   parameter int ABORT_FRAMES = 2,
   parameter bit IRQ_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              mx_n,
   input  logic [DATA_W-1:0] mon_byte,
   output logic              mr_n,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   input  logic              byte_ready,
   input  logic              mask_we,
   input  logic [REG_W-1:0]  mask_wdata,
   input  logic              stat_clr_we,
   input  logic [REG_W-1:0]  stat_clr_data,
   output logic [REG_W-1:0]  status,
   output logic [REG_W-1:0]  mask,
   output logic              irq
);
   logic load, abort_evt;

   mon_rx_fsm #(.ABORT_FRAMES(ABORT_FRAMES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_n(mx_n),
      .buf_busy(byte_valid), .mr_n(mr_n), .load(load), .abort_evt(abort_evt)
   );

   mon_rx_outbuf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .load(load), .din(mon_byte),
      .ready(byte_ready), .valid(byte_valid), .dout(byte_data)
   );

   mon_rx_regs #(.REG_W(REG_W), .ABORT_BIT(ABORT_BIT), .IRQ_REG(IRQ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .abort_evt(abort_evt),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .clr_we(stat_clr_we), .clr_data(stat_clr_data),
      .status(status), .mask(mask), .irq(irq)
   );

   assert_idle_no_accept_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_n && byte_valid && !byte_ready && frame_stb) |=> mr_n);
endmodule

// File: tb/mon_rx_handshake_tb.sv
module mon_rx_handshake_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0, mx_n = 1'b1, byte_ready = 1'b1;
   logic [7:0] mon_byte = 8'h00;
   logic mask_we = 1'b0, stat_clr_we = 1'b0;
   logic [7:0] mask_wdata = 8'h00, stat_clr_data = 8'h00;
   logic mr_n, byte_valid, irq;
   logic [7:0] byte_data, status, mask;

   int vectors = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mon_rx_handshake u_dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_n(mx_n),
      .mon_byte(mon_byte), .mr_n(mr_n), .byte_valid(byte_valid),
      .byte_data(byte_data), .byte_ready(byte_ready), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .stat_clr_we(stat_clr_we),
      .stat_clr_data(stat_clr_data), .status(status), .mask(mask), .irq(irq)
   );

   // behavioural reference: phase 0 idle, 1 acked, 2 one gap frame,
   // 3 byte waiting (hold-off), 4 released awaiting byte
   int ph = 0;
   int gaps = 0;
   logic e_mr = 1'b1, e_valid = 1'b0, e_irq = 1'b0;
   logic [7:0] e_data = 8'h00, e_status = 8'h00, e_mask = 8'h00;
   logic [7:0] q_bytes[$];

   always @(posedge clk) begin
      bit take, abt, was_full;
      if (!rst_n) begin
         ph = 0; gaps = 0; e_valid = 0; e_data = 0; e_status = 0; e_mask = 0;
      end else begin
         take = 0; abt = 0; was_full = e_valid;
         if (frame_stb) begin
            if (ph == 0) begin
               if (!mx_n && !was_full) begin take = 1; ph = 1; end
            end else if (ph == 1) begin
               if (mx_n) ph = 2;
            end else if (ph == 2) begin
               if (mx_n) ph = 0;
               else begin gaps = 0; ph = was_full ? 3 : 4; end
            end else begin
               if (mx_n) begin
                  gaps++;
                  if (gaps >= 2) begin abt = 1; ph = 0; end
               end else begin
                  gaps = 0;
                  if (ph == 4) begin take = 1; ph = 1; end
                  else if (!was_full) ph = 4;
               end
            end
         end
         if (take) begin e_valid = 1; e_data = mon_byte; q_bytes.push_back(mon_byte); end
         else if (byte_ready) e_valid = 0;
         if (stat_clr_we && stat_clr_data[3]) e_status[3] = 1'b0;
         if (abt) e_status[3] = 1'b1;
         if (mask_we) e_mask = mask_wdata;
      end
      e_mr = (ph == 0 || ph == 4);
      e_irq = |(e_status & e_mask);
   end

   task automatic cmp(input int act, input int exp, input string tag);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         cmp(mr_n, e_mr, "R3 mr_n vs model");
         cmp(byte_valid, e_valid, "R6 byte_valid vs model");
         if (e_valid) cmp(byte_data, e_data, "R2 byte_data vs model");
         cmp(status, e_status, "R10 status vs model");
         cmp(mask, e_mask, "R9 mask vs model");
         cmp(irq, e_irq, "R9 irq vs model");
      end
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic frame(input logic mx, input logic [7:0] b);
      @(negedge clk);
      mx_n = mx; mon_byte = b;
      @(negedge clk);
      @(negedge clk);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   task automatic pulse_clear(input logic [7:0] d);
      @(negedge clk);
      stat_clr_we = 1'b1; stat_clr_data = d;
      @(negedge clk);
      stat_clr_we = 1'b0;
   endtask

   task automatic set_mask(input logic [7:0] d);
      @(negedge clk);
      mask_we = 1'b1; mask_wdata = d;
      @(negedge clk);
      mask_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cmp(mr_n, 1, "R1 mr_n in reset");
      cmp(byte_valid, 0, "R1 byte_valid in reset");
      cmp(status, 0, "R1 status in reset");
      cmp(irq, 0, "R1 irq in reset");
      rst_n = 1'b1;
      @(negedge clk);
      cmp(mask, 0, "R1 mask after reset");

      // message with two bytes and normal end
      frame(1'b1, 8'h00);
      frame(1'b0, 8'hA1);
      cmp(mr_n, 0, "R2 ack on first byte");
      cmp(byte_valid, 1, "R2 valid on first byte");
      cmp(byte_data, 8'hA1, "R2 first byte data");
      // toggle flags without a strobe: no effect
      mx_n = 1'b1; mon_byte = 8'h55;
      repeat (4) @(negedge clk);
      cmp(mr_n, 0, "R3 no change between strobes");
      frame(1'b0, 8'hA1);
      cmp(byte_valid, 0, "R4 repeated byte not taken again");
      frame(1'b1, 8'hA2);
      cmp(mr_n, 0, "R4 mr held in gap frame");
      frame(1'b0, 8'hA2);
      cmp(mr_n, 1, "R4 mr released on reactivation");
      cmp(byte_valid, 0, "R4 no load on reactivation frame");
      frame(1'b0, 8'hA2);
      cmp(mr_n, 0, "R4 ack of second byte");
      cmp(byte_data, 8'hA2, "R4 second byte data");
      frame(1'b1, 8'h00);
      frame(1'b1, 8'h00);
      cmp(mr_n, 1, "R7 end of message releases mr");
      cmp(status, 0, "R7 no status on end of message");

      // back-pressure
      byte_ready = 1'b0;
      frame(1'b0, 8'hB1);
      frame(1'b1, 8'hB2);
      frame(1'b0, 8'hB2);
      cmp(mr_n, 0, "R5 hold-off keeps mr active");
      frame(1'b0, 8'hB2);
      cmp(mr_n, 0, "R5 still held");
      cmp(byte_data, 8'hB1, "R6 data held while not ready");
      byte_ready = 1'b1;
      @(negedge clk);
      cmp(byte_valid, 0, "R6 valid drops on ready");
      frame(1'b0, 8'hB2);
      cmp(mr_n, 1, "R5 release once drained");
      frame(1'b0, 8'hB2);
      cmp(byte_data, 8'hB2, "R5 byte after hold-off");
      frame(1'b1, 8'h00);
      frame(1'b1, 8'h00);

      // abort with interrupt unmasked
      set_mask(8'h08);
      frame(1'b0, 8'hC1);
      frame(1'b1, 8'hC2);
      frame(1'b0, 8'hC2);
      frame(1'b1, 8'hC2);
      cmp(status, 0, "R8 one frame is not an abort");
      frame(1'b1, 8'hC2);
      cmp(status, 8'h08, "R8 abort sets bit 3");
      cmp(mr_n, 1, "R8 mr idle after abort");
      cmp(irq, 1, "R9 irq when unmasked");
      pulse_clear(8'h00);
      cmp(status, 8'h08, "R10 zero write keeps status");
      pulse_clear(8'h08);
      cmp(status, 0, "R10 write one clears");
      cmp(irq, 0, "R9 irq drops after clear");

      // abort with interrupt masked, from hold-off
      set_mask(8'h00);
      byte_ready = 1'b0;
      frame(1'b0, 8'hD1);
      frame(1'b1, 8'hD2);
      frame(1'b0, 8'hD2);
      frame(1'b1, 8'hD2);
      frame(1'b1, 8'hD2);
      cmp(status, 8'h08, "R8 abort from hold-off");
      cmp(irq, 0, "R9 masked abort no irq");

      // idle with full buffer
      frame(1'b0, 8'hE1);
      cmp(mr_n, 1, "R11 not accepted while full");
      cmp(byte_data, 8'hD1, "R11 old byte kept");
      byte_ready = 1'b1;
      @(negedge clk);
      frame(1'b0, 8'hE1);
      cmp(mr_n, 0, "R11 accepted once empty");
      cmp(byte_data, 8'hE1, "R11 new byte data");
      frame(1'b1, 8'h00);
      frame(1'b1, 8'h00);
      pulse_clear(8'hFF);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule